// File: doc/BRIEF.md
# Protection Level Escalation Engine

This block is a hardware sequencer that tightens the access rights of a bus firewall after the firewall has reported an attack. A monitor sends a request that names the firewall and says whether the IP behind it is critical. The engine reads the firewall's first policy word to find its current access level and picks the next, stricter level. It then walks through every policy word of that firewall, one word per cycle. For each word it saves the original into a backup memory and writes the word back with only its access field changed. When the last word is written, it pulses a completion strobe that carries the firewall index, so the monitor can let that firewall's traffic flow again.

The escalation path depends on the criticality bit. A critical IP is isolated (quarantined) on its first attack. A non-critical IP first drops to read-only, which still lets its data be read out, and is isolated on a later attack. An attack on a firewall that is already isolated writes nothing. Instead the engine raises a one-cycle request for a full system reboot. Requests that arrive while the engine is busy wait in a small queue and are served in the order they arrived.

Each firewall owns `WORDS_PER_FW` consecutive policy words starting at address `fw * WORDS_PER_FW`. The policy memory has a read port with one cycle of latency and a separate write port.

Top module: `polEscalator`

## Requirements
- R1: After reset, no policy or backup write is issued, `doneValid` and `rebootReq` are low, and `reqReady` is high.
- R2: The access field is bits [1:0] of each policy word: bit 1 allows writes and bit 0 allows reads. So 2'b11 means read/write, 2'b01 means read-only and 2'b00 means quarantine. When the request has `reqCritical`=1 and word 0 is not 2'b00, every word of the firewall is rewritten with access 2'b00.
- R3: For a non-critical request whose word-0 access has bit 1 set (2'b11 or 2'b10), every word is rewritten with access 2'b01.
- R4: For a non-critical request whose word-0 access is 2'b01, every word is rewritten with access 2'b00.
- R5: When word-0 access is 2'b00, `rebootReq` is high for exactly one cycle. No policy write, no backup write and no `doneValid` follow for that request.
- R6: A rewrite changes only bits [1:0]; bits [DATA_W-1:2] of each word keep their prior value.
- R7: In the cycle that policy word at address A is rewritten, its original value is written to the backup port at address A.
- R8: The WORDS_PER_FW writes for firewall f fall in consecutive cycles at addresses f*WORDS_PER_FW upward. `doneValid` is high for one cycle right after the last write, with `doneFw`=f. With the engine idle, `doneValid` is sampled high at the (WORDS_PER_FW+4)-th rising edge after the edge that accepted the request.
- R9: Requests are served in arrival order, and a queued request's `doneValid` comes WORDS_PER_FW+4 cycles after the previous one's. `reqReady` is low while the queue holds FIFO_DEPTH entries, and a request offered while `reqReady` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Escalation request strobe |
| reqFw | input | FW_W | Index of the attacked firewall |
| reqCritical | input | 1 | IP behind the firewall is critical |
| reqReady | output | 1 | Queue can take a request |
| polRdEn | output | 1 | Policy memory read enable |
| polRdAddr | output | ADDR_W | Policy memory read address |
| polRdData | input | DATA_W | Policy read data, one cycle after the read |
| polWrEn | output | 1 | Policy memory write enable |
| polWrAddr | output | ADDR_W | Policy memory write address |
| polWrData | output | DATA_W | Escalated policy word |
| bkWrEn | output | 1 | Backup memory write enable |
| bkWrAddr | output | ADDR_W | Backup memory write address |
| bkWrData | output | DATA_W | Original policy word being saved |
| doneValid | output | 1 | Firewall update finished (one cycle) |
| doneFw | output | FW_W | Firewall index for the completion |
| rebootReq | output | 1 | System reboot request (one cycle) |

## Verification
The hardest condition to reach from the ports is a full queue while the engine is busy. Only then does `reqReady` fall, and only then can a request be lost or served out of order. The bench offers six requests on consecutive cycles right after the engine starts one update, so the queue fills before anything leaves it. It then checks that the sixth request leaves no trace and that the same firewall named twice in the queue is escalated twice, in order. The reboot path needs a firewall that is already quarantined, so the bench first escalates one critical firewall and then attacks it again.

// File: rtl/polEscPkg.sv
package polEscPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SAVE,
    ST_WRITE,
    ST_DONE,
    ST_REBOOT
  } escState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;  // latch the popped request, clear word index
    logic rdEn;     // issue a policy read
    logic rdNext;   // read address is word index + 1
    logic decide;   // latch escalated access level from read data
    logic wrEn;     // write policy and backup word, advance index
  } escCtrl_t;

  localparam logic [1:0] ACC_RW   = 2'b11;
  localparam logic [1:0] ACC_RO   = 2'b01;
  localparam logic [1:0] ACC_QUAR = 2'b00;

  // bit 1 = write allowed, bit 0 = read allowed
  function automatic logic [1:0] escalateAcc(input logic [1:0] cur, input logic critical);
    if (critical || !cur[1]) return ACC_QUAR;
    return ACC_RO;
  endfunction

endpackage

// File: rtl/escReqFifo.sv
module escReqFifo #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = store[rdPtr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        store[wrPtr] <= pushData;
        wrPtr        <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R9: control never pops an empty queue
  assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> !empty);

endmodule

// File: rtl/escControl.sv
module escControl
  import polEscPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoEmpty,
  input  logic     isQuar,
  input  logic     lastWord,
  output logic     fifoPop,
  output escCtrl_t ctrl,
  output logic     doneValid,
  output logic     rebootReq
);
  escState_e state, nextState;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    fifoPop   = 1'b0;
    case (state)
      ST_IDLE: if (!fifoEmpty) begin
        fifoPop      = 1'b1;
        ctrl.loadReq = 1'b1;
        nextState    = ST_READ;
      end
      ST_READ: begin
        ctrl.rdEn = 1'b1;
        nextState = ST_SAVE;
      end
      ST_SAVE: begin
        if (isQuar) begin
          nextState = ST_REBOOT;
        end else begin
          ctrl.decide = 1'b1;
          ctrl.rdEn   = 1'b1;   // re-read word 0 for the write pass
          nextState   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        ctrl.wrEn   = 1'b1;
        ctrl.rdEn   = !lastWord;
        ctrl.rdNext = 1'b1;
        if (lastWord) nextState = ST_DONE;
      end
      ST_DONE:   nextState = ST_IDLE;
      ST_REBOOT: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign doneValid = (state == ST_DONE);
  assign rebootReq = (state == ST_REBOOT);

  // R5: reboot only after word 0 showed quarantine, and only one cycle long
  assert_reboot_on_quar_R5: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |-> $past(isQuar));
  assert_reboot_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |=> !rebootReq);
  // R8: completion follows the write of the last word
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> $past(lastWord));

endmodule

// File: rtl/escDatapath.sv
module escDatapath
  import polEscPkg::*;
#(
  parameter int FW_COUNT     = 4,
  parameter int WORDS_PER_FW = 3,
  parameter int DATA_W       = 32,
  parameter int FW_W         = 2,
  parameter int ADDR_W       = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  escCtrl_t          ctrl,
  input  logic [FW_W-1:0]   popFw,
  input  logic              popCrit,
  input  logic [DATA_W-1:0] polRdData,
  output logic              isQuar,
  output logic              lastWord,
  output logic              polRdEn,
  output logic [ADDR_W-1:0] polRdAddr,
  output logic              polWrEn,
  output logic [ADDR_W-1:0] polWrAddr,
  output logic [DATA_W-1:0] polWrData,
  output logic              bkWrEn,
  output logic [ADDR_W-1:0] bkWrAddr,
  output logic [DATA_W-1:0] bkWrData,
  output logic [FW_W-1:0]   curFwOut
);
  localparam int IDX_W = (WORDS_PER_FW > 1) ? $clog2(WORDS_PER_FW) : 1;

  logic [FW_W-1:0]   curFw;
  logic              curCrit;
  logic [IDX_W-1:0]  wordIdx;
  logic [1:0]        targetAcc;
  logic [ADDR_W-1:0] baseAddr;
  logic [ADDR_W-1:0] rdIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curFw     <= '0;
      curCrit   <= 1'b0;
      wordIdx   <= '0;
      targetAcc <= ACC_QUAR;
    end else begin
      if (ctrl.loadReq) begin
        curFw   <= popFw;
        curCrit <= popCrit;
        wordIdx <= '0;
      end
      if (ctrl.decide) targetAcc <= escalateAcc(polRdData[1:0], curCrit);
      if (ctrl.wrEn && !lastWord) wordIdx <= wordIdx + 1'b1;
    end
  end

  assign baseAddr  = ADDR_W'(curFw) * ADDR_W'(WORDS_PER_FW);
  assign rdIdx     = ctrl.rdNext ? ADDR_W'(wordIdx) + 1'b1 : ADDR_W'(wordIdx);
  assign isQuar    = (polRdData[1:0] == ACC_QUAR);
  assign lastWord  = (wordIdx == IDX_W'(WORDS_PER_FW - 1));

  assign polRdEn   = ctrl.rdEn;
  assign polRdAddr = baseAddr + rdIdx;
  assign polWrEn   = ctrl.wrEn;
  assign polWrAddr = baseAddr + ADDR_W'(wordIdx);
  assign polWrData = {polRdData[DATA_W-1:2], targetAcc};
  assign bkWrEn    = ctrl.wrEn;
  assign bkWrAddr  = baseAddr + ADDR_W'(wordIdx);
  assign bkWrData  = polRdData;
  assign curFwOut  = curFw;

  // R3: an escalated word never keeps write permission
  assert_no_write_perm_R3: assert property (@(posedge clk) disable iff (!rstN)
    polWrEn |-> !polWrData[1]);
  // R8: word index stays inside the firewall's policy block
  assert_idx_bounded_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordIdx <= IDX_W'(WORDS_PER_FW - 1));
  // R8: writes land inside the policy memory
  assert_addr_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    polWrEn |-> (int'(polWrAddr) < FW_COUNT * WORDS_PER_FW));

endmodule

// File: rtl/polEscalator.sv
module polEscalator
  import polEscPkg::*;
#(
  parameter int FW_COUNT     = 4,
  parameter int WORDS_PER_FW = 3,
  parameter int DATA_W       = 32,
  parameter int FIFO_DEPTH   = 4,
  localparam int FW_W        = (FW_COUNT > 1) ? $clog2(FW_COUNT) : 1,
  localparam int ADDR_W      = (FW_COUNT * WORDS_PER_FW > 1) ? $clog2(FW_COUNT * WORDS_PER_FW) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [FW_W-1:0]   reqFw,
  input  logic              reqCritical,
  output logic              reqReady,
  output logic              polRdEn,
  output logic [ADDR_W-1:0] polRdAddr,
  input  logic [DATA_W-1:0] polRdData,
  output logic              polWrEn,
  output logic [ADDR_W-1:0] polWrAddr,
  output logic [DATA_W-1:0] polWrData,
  output logic              bkWrEn,
  output logic [ADDR_W-1:0] bkWrAddr,
  output logic [DATA_W-1:0] bkWrData,
  output logic              doneValid,
  output logic [FW_W-1:0]   doneFw,
  output logic              rebootReq
);
  escCtrl_t        ctrl;
  logic            fifoEmpty, fifoFull, fifoPop;
  logic [FW_W:0]   popEntry;
  logic            isQuar, lastWord;

  escReqFifo #(.WIDTH(FW_W + 1), .DEPTH(FIFO_DEPTH)) uFifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (reqValid),
    .pushData ({reqFw, reqCritical}),
    .pop      (fifoPop),
    .popData  (popEntry),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign reqReady = !fifoFull;

  escControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .fifoEmpty (fifoEmpty),
    .isQuar    (isQuar),
    .lastWord  (lastWord),
    .fifoPop   (fifoPop),
    .ctrl      (ctrl),
    .doneValid (doneValid),
    .rebootReq (rebootReq)
  );

  escDatapath #(
    .FW_COUNT(FW_COUNT), .WORDS_PER_FW(WORDS_PER_FW), .DATA_W(DATA_W),
    .FW_W(FW_W), .ADDR_W(ADDR_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .popFw     (popEntry[FW_W:1]),
    .popCrit   (popEntry[0]),
    .polRdData (polRdData),
    .isQuar    (isQuar),
    .lastWord  (lastWord),
    .polRdEn   (polRdEn),
    .polRdAddr (polRdAddr),
    .polWrEn   (polWrEn),
    .polWrAddr (polWrAddr),
    .polWrData (polWrData),
    .bkWrEn    (bkWrEn),
    .bkWrAddr  (bkWrAddr),
    .bkWrData  (bkWrData),
    .curFwOut  (doneFw)
  );

  // R5: a reboot request never coincides with a policy write
  assert_reboot_no_write_R5: assert property (@(posedge clk) disable iff (!rstN)
    rebootReq |-> !polWrEn && !bkWrEn);
  // R7: each policy write is paired with a backup write to the same address
  assert_backup_paired_R7: assert property (@(posedge clk) disable iff (!rstN)
    polWrEn |-> bkWrEn && (bkWrAddr == polWrAddr));

endmodule

// File: tb/polEscalator_test.sv
module polEscalator_test;
  localparam int FWN = 4;
  localparam int NW  = 3;
  localparam int DW  = 32;
  localparam int MEMN = FWN * NW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqFw = '0;
  logic          reqCritical = 1'b0;
  logic          reqReady;
  logic          polRdEn, polWrEn, bkWrEn, doneValid, rebootReq;
  logic [3:0]    polRdAddr, polWrAddr, bkWrAddr;
  logic [DW-1:0] polRdData = '0, polWrData, bkWrData;
  logic [1:0]    doneFw;

  always #2.5 clk = ~clk;   // 200 MHz

  polEscalator uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFw(reqFw),
    .reqCritical(reqCritical), .reqReady(reqReady),
    .polRdEn(polRdEn), .polRdAddr(polRdAddr), .polRdData(polRdData),
    .polWrEn(polWrEn), .polWrAddr(polWrAddr), .polWrData(polWrData),
    .bkWrEn(bkWrEn), .bkWrAddr(bkWrAddr), .bkWrData(bkWrData),
    .doneValid(doneValid), .doneFw(doneFw), .rebootReq(rebootReq)
  );

  logic [DW-1:0] polMem [MEMN];
  logic [DW-1:0] bkMem  [MEMN];
  logic [DW-1:0] preMem [MEMN];
  int cyc = 0, pushCyc = 0;
  int wrCount = 0, bkCount = 0, firstWr = -1, lastWr = -1, wrBadAddr = 0;
  int doneCount = 0, rebootCount = 0;
  int doneIdx [16];
  int doneCyc [16];
  int checks = 0, errors = 0;
  bit finished = 0;

  // memory model and event monitor
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (polRdEn) polRdData <= polMem[polRdAddr];
    if (polWrEn) begin
      polMem[polWrAddr] <= polWrData;
      if (firstWr < 0) firstWr <= cyc;
      lastWr  <= cyc;
      wrCount <= wrCount + 1;
    end
    if (bkWrEn) begin
      bkMem[bkWrAddr] <= bkWrData;
      bkCount <= bkCount + 1;
      if (!polWrEn || bkWrAddr != polWrAddr) wrBadAddr <= wrBadAddr + 1;
    end
    if (reqValid && reqReady) pushCyc <= cyc;
    if (doneValid && doneCount < 16) begin
      doneIdx[doneCount] <= int'(doneFw);
      doneCyc[doneCount] <= cyc;
      doneCount <= doneCount + 1;
    end
    if (rebootReq) rebootCount <= rebootCount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] refEsc(input logic [1:0] cur, input bit crit);
    if (crit) return 2'b00;
    if (cur == 2'b01) return 2'b00;
    return 2'b01;
  endfunction

  task automatic initFw(input int fw, input logic [1:0] acc);
    for (int i = 0; i < NW; i++) begin
      polMem[fw*NW+i] = 32'h5A00_0000 ^ (32'(fw*NW+i) << 12) ^ 32'h0000_0C3C | {30'd0, acc};
      polMem[fw*NW+i][1:0] = acc;
      bkMem[fw*NW+i] = '0;
    end
  endtask

  task automatic snap();
    for (int i = 0; i < MEMN; i++) preMem[i] = polMem[i];
  endtask

  task automatic clearMon();
    @(negedge clk);
    wrCount = 0; bkCount = 0; firstWr = -1; lastWr = -1; wrBadAddr = 0;
    doneCount = 0; rebootCount = 0;
  endtask

  task automatic sendReq(input int fw, input bit crit);
    @(negedge clk);
    reqValid = 1'b1; reqFw = 2'(fw); reqCritical = crit;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDones(input int n);
    for (int k = 0; k < 200 && doneCount < n; k++) @(negedge clk);
  endtask

  task automatic checkFwWords(input int fw, input logic [1:0] expAcc, input string tag);
    for (int i = 0; i < NW; i++) begin
      int a = fw*NW + i;
      check(polMem[a][1:0] == expAcc, {tag, " access field"}, int'(polMem[a][1:0]), int'(expAcc));
      check(polMem[a][DW-1:2] == preMem[a][DW-1:2], "R6 upper bits preserved",
            int'(polMem[a][DW-1:2]), int'(preMem[a][DW-1:2]));
      check(bkMem[a] == preMem[a], "R7 backup holds original", int'(bkMem[a]), int'(preMem[a]));
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    check(reqReady == 1'b1, "R1 reqReady after reset", int'(reqReady), 1);
    check(doneValid == 1'b0, "R1 doneValid after reset", int'(doneValid), 0);
    check(rebootReq == 1'b0, "R1 rebootReq after reset", int'(rebootReq), 0);
    check(polWrEn == 1'b0 && bkWrEn == 1'b0, "R1 no writes after reset", int'(polWrEn), 0);
  endtask

  // single escalation with exact timing
  task automatic tEscalate(input int fw, input bit crit, input string tag);
    logic [1:0] expAcc;
    expAcc = refEsc(polMem[fw*NW][1:0], crit);
    snap();
    clearMon();
    sendReq(fw, crit);
    waitDones(1);
    repeat (3) @(negedge clk);
    check(doneCount == 1, "R8 one completion", doneCount, 1);
    check(doneIdx[0] == fw, "R8 doneFw index", doneIdx[0], fw);
    check(doneCyc[0] - pushCyc == NW + 4, "R8 completion latency", doneCyc[0] - pushCyc, NW + 4);
    check(wrCount == NW && lastWr - firstWr == NW - 1, "R8 consecutive writes", wrCount, NW);
    check(doneCyc[0] == lastWr + 1, "R8 done right after last write", doneCyc[0], lastWr + 1);
    check(bkCount == NW && wrBadAddr == 0, "R7 backup writes paired", bkCount, NW);
    checkFwWords(fw, expAcc, tag);
  endtask

  task automatic tReboot(input int fw);
    snap();
    clearMon();
    sendReq(fw, 1'b0);
    repeat (12) @(negedge clk);
    check(rebootCount == 1, "R5 reboot pulse count", rebootCount, 1);
    check(wrCount == 0 && bkCount == 0, "R5 no writes on reboot", wrCount + bkCount, 0);
    check(doneCount == 0, "R5 no completion on reboot", doneCount, 0);
    for (int i = 0; i < NW; i++)
      check(polMem[fw*NW+i] == preMem[fw*NW+i], "R5 policy untouched",
            int'(polMem[fw*NW+i][1:0]), int'(preMem[fw*NW+i][1:0]));
  endtask

  task automatic tQueue();
    int fws [6] = '{0, 1, 2, 3, 0, 1};
    bit expRdy [6] = '{1, 1, 1, 1, 1, 0};
    int expOrder [5] = '{0, 1, 2, 3, 0};
    for (int f = 0; f < FWN; f++) initFw(f, 2'b11);
    snap();
    clearMon();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(reqReady == expRdy[k], "R9 reqReady while filling", int'(reqReady), int'(expRdy[k]));
      reqValid = 1'b1; reqFw = 2'(fws[k]); reqCritical = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b0;
    waitDones(5);
    repeat (30) @(negedge clk);
    check(doneCount == 5, "R9 dropped request not served", doneCount, 5);
    for (int k = 0; k < 5; k++)
      check(doneIdx[k] == expOrder[k], "R9 arrival order", doneIdx[k], expOrder[k]);
    for (int k = 1; k < 5; k++)
      check(doneCyc[k] - doneCyc[k-1] == NW + 4, "R9 queued spacing",
            doneCyc[k] - doneCyc[k-1], NW + 4);
    check(polMem[0][1:0] == 2'b00, "R4 second attack quarantines fw0", int'(polMem[0][1:0]), 0);
    check(polMem[NW][1:0] == 2'b01, "R9 fw1 escalated once", int'(polMem[NW][1:0]), 1);
    check(polMem[2*NW][1:0] == 2'b01 && polMem[3*NW][1:0] == 2'b01, "R3 fw2 fw3 read-only",
          int'(polMem[2*NW][1:0]), 1);
  endtask

  initial begin
    for (int f = 0; f < FWN; f++) initFw(f, 2'b11);
    initFw(2, 2'b10);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tEscalate(1, 1'b1, "R2 critical to quarantine");
    tEscalate(2, 1'b0, "R3 write-only to read-only");
    tEscalate(2, 1'b0, "R4 read-only to quarantine");
    tEscalate(3, 1'b0, "R3 read/write to read-only");
    tReboot(1);
    tQueue();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule